// File: doc/BRIEF.md
# Two's-Complement Adder/Subtractor with Signed Overflow Flag

This block adds or subtracts two N-bit operands in two's complement and reports the wrapped N-bit result, the carry leaving the top bit, and a flag that marks a signed result outside the representable range. It is purely combinational: the outputs follow the operands and the mode input with no clock, no reset and no stored state.

The datapath is a chain of one-bit full-adder cells. Each cell passes its carry to the cell above it. A single mode input picks the operation. When it is low the block adds. When it is high the block subtracts by inverting every bit of the second operand and feeding a carry of 1 into the lowest cell, which adds the two's complement of that operand.

The overflow flag compares the carry entering the most significant cell with the carry leaving it. The block has no states and no transitions.

Top module: `addsub_unit`

## Requirements
- R1: With op_sel = 0 (sum mode), result_o equals (a_i + b_i) modulo 2^N.
- R2: With op_sel = 1 (difference mode), result_o equals (a_i - b_i) modulo 2^N.
- R3: In sum mode, carry_o is 1 exactly when the unsigned sum a_i + b_i is 2^N or more.
- R4: In difference mode, carry_o is 1 exactly when a_i is greater than or equal to b_i as unsigned numbers, meaning no borrow occurs.
- R5: ovf_o is 1 exactly when the true signed result of the selected operation lies outside -2^(N-1) .. 2^(N-1)-1, with a_i and b_i read as two's complement.
- R6: In sum mode, operands whose most significant bits differ never set ovf_o. For N = 4, 0111 + 1000 gives 1111 with ovf_o = 0.
- R7: For N = 4 in sum mode, 0111 + 0111 gives 1110 with ovf_o = 1, and 1001 + 1001 gives 0010 with ovf_o = 1.
- R8: The outputs are combinational. A change on a_i, b_i or op_sel shows at the outputs without any clock edge.
- R9: The width N is a parameter with a default of 4. At N = 8 the same arithmetic and flag rules hold at the range limits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First operand, two's complement |
| b_i | input | N | Second operand, two's complement |
| op_sel | input | 1 | Mode: 0 adds, 1 subtracts |
| result_o | output | N | Wrapped result |
| carry_o | output | 1 | Carry out of the most significant cell |
| ovf_o | output | 1 | Signed overflow or underflow |

## Verification
The bench builds two copies of the block. One uses the default width N = 4. At that width all 256 operand pairs can be driven in both modes, so every carry pattern through the chain and every overflow and underflow case is covered and compared with an integer model. The second copy uses N = 8. It is driven with operands at and around the signed and unsigned limits, which shows that the flag and carry rules are not tied to four bits.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    // Operation selected by the mode input (active-low sum).
    typedef enum logic {
        MODE_SUM  = 1'b0,
        MODE_DIFF = 1'b1
    } addsub_mode_e;

endpackage

// File: rtl/addsub_fa.sv
module addsub_fa (
    input  logic x_i,
    input  logic y_i,
    input  logic cin_i,
    output logic s_o,
    output logic cout_o
);

    logic half_s;

    always_comb begin
        half_s = x_i ^ y_i;
        s_o    = half_s ^ cin_i;
        cout_o = (x_i & y_i) | (half_s & cin_i);
    end

endmodule

// File: rtl/addsub_chain.sv
module addsub_chain #(
    parameter int N = 4
) (
    input  logic [N-1:0] x_i,
    input  logic [N-1:0] y_i,
    input  logic         cin_i,
    output logic [N-1:0] s_o,
    output logic         c_msb_in_o,
    output logic         c_out_o
);

    localparam int MSB = N - 1;

    logic [N:0] carry;

    assign carry[0] = cin_i;

    generate
        for (genvar k = 0; k < N; k++) begin : g_cell
            addsub_fa u_fa (
                .x_i   (x_i[k]),
                .y_i   (y_i[k]),
                .cin_i (carry[k]),
                .s_o   (s_o[k]),
                .cout_o(carry[k+1])
            );
        end
    endgenerate

    assign c_msb_in_o = carry[MSB];
    assign c_out_o    = carry[N];

endmodule

// File: rtl/addsub_vflag.sv
module addsub_vflag (
    input  logic c_msb_in_i,
    input  logic c_msb_out_i,
    output logic v_o
);

    assign v_o = c_msb_in_i ^ c_msb_out_i;

endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
    import addsub_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    input  logic         op_sel,
    output logic [N-1:0] result_o,
    output logic         carry_o,
    output logic         ovf_o
);

    localparam int MSB = N - 1;

    addsub_mode_e mode;
    logic [N-1:0] b_cond;
    logic         c_msb_in;
    logic         c_msb_out;

    // Operand conditioning: invert B and inject a carry for subtraction.
    always_comb begin
        mode   = addsub_mode_e'(op_sel);
        b_cond = (mode == MODE_DIFF) ? ~b_i : b_i;
    end

    addsub_chain #(.N(N)) u_chain (
        .x_i       (a_i),
        .y_i       (b_cond),
        .cin_i     (mode == MODE_DIFF),
        .s_o       (result_o),
        .c_msb_in_o(c_msb_in),
        .c_out_o   (c_msb_out)
    );

    addsub_vflag u_vflag (
        .c_msb_in_i (c_msb_in),
        .c_msb_out_i(c_msb_out),
        .v_o        (ovf_o)
    );

    assign carry_o = c_msb_out;

    // Checks against arithmetic written independently of the cell chain.
    always_comb begin
        if (!$isunknown({a_i, b_i, op_sel, result_o, carry_o, ovf_o})) begin
            if (op_sel == 1'b0) begin
                assert_sum_value_R1: assert ({carry_o, result_o} == ({1'b0, a_i} + {1'b0, b_i}))
                    else $error("sum/carry mismatch");
                assert_sum_flag_R5: assert (ovf_o == ((a_i[MSB] == b_i[MSB]) && (result_o[MSB] != a_i[MSB])))
                    else $error("sum overflow flag mismatch");
                assert_no_overflow_R6: assert (!((a_i[MSB] != b_i[MSB]) && ovf_o))
                    else $error("mixed-sign sum flagged");
            end else begin
                assert_diff_value_R2: assert (result_o == N'(a_i - b_i))
                    else $error("difference mismatch");
                assert_diff_carry_R4: assert (carry_o == (a_i >= b_i))
                    else $error("borrow mismatch");
                assert_diff_flag_R5: assert (ovf_o == ((a_i[MSB] != b_i[MSB]) && (result_o[MSB] != a_i[MSB])))
                    else $error("difference overflow flag mismatch");
            end
        end
    end

endmodule

// File: tb/test_addsub_unit.sv
module test_addsub_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NA = 4;
    localparam int NB = 8;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [NA-1:0] a4, b4, r4;
    logic          s4, c4, v4;
    logic [NB-1:0] a8, b8, r8;
    logic          s8, c8, v8;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    addsub_unit #(.N(NA)) i_addsub_unit (
        .a_i(a4), .b_i(b4), .op_sel(s4),
        .result_o(r4), .carry_o(c4), .ovf_o(v4)
    );

    addsub_unit #(.N(NB)) i_addsub_unit_wide (
        .a_i(a8), .b_i(b8), .op_sel(s8),
        .result_o(r8), .carry_o(c8), .ovf_o(v8)
    );

    // Integer model of the requirements.
    task automatic model(input int w, input int ua, input int ub, input bit sub,
                         output int res, output bit cy, output bit ov);
        int full = 1 << w;
        int half = 1 << (w - 1);
        int sa   = (ua >= half) ? ua - full : ua;
        int sb   = (ub >= half) ? ub - full : ub;
        int t    = sub ? sa - sb : sa + sb;
        ov  = (t > half - 1) || (t < -half);
        res = ((t % full) + full) % full;
        cy  = sub ? (ua >= ub) : ((ua + ub) >= full);
    endtask

    task automatic compare(input bit wide, input string tag, input int ua, input int ub,
                           input bit sub, input int got_r, input bit got_c, input bit got_v);
        int er; bit ec; bit ev;
        model(wide ? NB : NA, ua, ub, sub, er, ec, ev);
        n_checks++;
        if (got_r != er || got_c != ec || got_v != ev) begin
            n_fail++;
            $display("FAIL %s a=%0d b=%0d sub=%0d: actual r=%0d c=%0d v=%0d expected r=%0d c=%0d v=%0d",
                     tag, ua, ub, sub, got_r, got_c, got_v, er, ec, ev);
        end
    endtask

    task automatic apply(input bit wide, input int ua, input int ub, input bit sub,
                         input string tag);
        @(negedge clk);
        if (wide) begin a8 = NB'(ua); b8 = NB'(ub); s8 = sub; end
        else      begin a4 = NA'(ua); b4 = NA'(ub); s4 = sub; end
        #(CLK_PERIOD/4);
        if (wide) compare(1'b1, tag, ua, ub, sub, int'(r8), c8, v8);
        else      compare(1'b0, tag, ua, ub, sub, int'(r4), c4, v4);
    endtask

    // Zero operands: the output state after start-up. R1
    task automatic t_zero();
        apply(1'b0, 0, 0, 1'b0, "R1 zero");
        apply(1'b1, 0, 0, 1'b0, "R1 zero wide");
    endtask

    // Named corner values. R7 R6
    task automatic t_named();
        apply(1'b0, 7, 7, 1'b0, "R7 7+7");
        apply(1'b0, 9, 9, 1'b0, "R7 -7+-7");
        apply(1'b0, 7, 8, 1'b0, "R6 7+-8");
    endtask

    // Every pair at N=4 in both modes. R1 R2 R3 R4 R5
    task automatic t_sweep();
        for (int m = 0; m < 2; m++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    apply(1'b0, a, b, m[0], m[0] ? "R2 R4 R5 sweep" : "R1 R3 R5 sweep");
    endtask

    // Mixed-sign sums never overflow. R6
    task automatic t_mixed();
        for (int a = 0; a < 8; a++)
            for (int b = 8; b < 16; b++) begin
                @(negedge clk);
                a4 = NA'(a); b4 = NA'(b); s4 = 1'b0;
                #(CLK_PERIOD/4);
                n_checks++;
                if (v4 !== 1'b0) begin
                    n_fail++;
                    $display("FAIL R6 a=%0d b=%0d: actual v=%0d expected v=0", a, b, v4);
                end
            end
    endtask

    // Output follows an input change without a clock edge. R8
    task automatic t_comb();
        int er; bit ec; bit ev;
        @(posedge clk);
        #1;
        a4 = 4'd5; b4 = 4'd6; s4 = 1'b0;
        #1;
        compare(1'b0, "R8 no-edge", 5, 6, 1'b0, int'(r4), c4, v4);
        s4 = 1'b1;
        #1;
        compare(1'b0, "R8 mode flip", 5, 6, 1'b1, int'(r4), c4, v4);
        model(NA, 5, 6, 1'b1, er, ec, ev);
    endtask

    // Range limits at N=8. R9
    task automatic t_wide();
        apply(1'b1, 127, 1,   1'b0, "R9 127+1");
        apply(1'b1, 128, 1,   1'b1, "R9 -128-1");
        apply(1'b1, 255, 1,   1'b0, "R9 255+1");
        apply(1'b1, 0,   1,   1'b1, "R9 0-1");
        apply(1'b1, 100, 156, 1'b1, "R9 100-(-100)");
        apply(1'b1, 127, 128, 1'b0, "R9 127+-128");
        apply(1'b1, 128, 128, 1'b0, "R9 -128+-128");
        apply(1'b1, 128, 127, 1'b1, "R9 -128-127");
        apply(1'b1, 77,  77,  1'b1, "R9 equal diff");
    endtask

    initial begin
        a4 = '0; b4 = '0; s4 = 1'b0;
        a8 = '0; b8 = '0; s8 = 1'b0;
        t_zero();
        t_named();
        t_sweep();
        t_mixed();
        t_comb();
        t_wide();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule